// File: doc/BRIEF.md
# Power-Stage Output Refresh Sequencer

This block is the controller that brings a multi-channel output-driver device into service and keeps its channel enables current. The driver device is reached through a command port that carries one register write at a time (a 5-bit register address plus an 8-bit data byte). A separate frame codec serialises each write, checks the reply and reports one response back as ok or error. After `start_i`, the sequencer issues a soft-reset write and then stays silent for a settling time. Next it unlocks the device and enables its power stages. From then on it rewrites four control registers as one burst.

Bursts repeat on a fixed period. A host write to a channel that is only reachable over the serial link triggers a burst sooner. The host provides a 33-bit requested channel state and a 33-bit enable mask. Channels 0 to 10 are also gated on the device by dedicated parallel pins. For those channels the serial bit sent is the enable-mask bit, so the parallel pin alone decides the output. A time-base parameter converts milliseconds into clock cycles.

Top module: `pwr_refresh_seq`

## Requirements
- R1: After reset, `drv_state_o` is 0 (disabled), `cmd_valid_o` is low and `sent_state_o` is zero. No command is issued until `start_i` is pulsed.
- R2: On start, the first command writes data 0x02 to address 0x0C (soft reset). No further command is issued until RESET_MS×CLK_PER_MS cycles after its ok response. While this phase runs, `drv_state_o` is 1. If the reset write gets an error response, the state becomes 3 (failed).
- R3: The initialisation writes 0x00 to address 0x0C and then 0x02 to address 0x0D. An error response on either write makes `drv_state_o` 3. No further command follows that error.
- R4: A refresh burst writes addresses 0x08, 0x09, 0x0A and 0x0B in that order. A burst follows each successful initialisation at once, and `drv_state_o` is 2 (ready) from then on.
- R5: The burst data bytes are built from the effective state e (bit 7 first):
  - 0x08 = {e4,e5,e6,e7,e8,e23,0,0}
  - 0x09 = {e18,e17,0,0,e0,e1,e2,e3}
  - 0x0A = {e25,e24,e19,e17,e20,e21,e10,e9}
  - 0x0B = {0,0,e31,e30,e29,e28,e27,e26}
- R6: For bits 0 to 10, e equals the enable-mask bit. For bits 11 to 32, e equals the requested-state bit. Both inputs are sampled when a burst starts.
- R7: A burst stops at the first error response. `sent_state_o` then keeps its old value. When all four writes succeed, `sent_state_o` takes the e that was sampled for that burst.
- R8: In ready, a new burst starts REFRESH_MS×CLK_PER_MS cycles after the previous burst has ended.
- R9: A pulse on `wr_valid_i` with `wr_idx_i` in 11 to 32 starts a burst within a few cycles. An index in 0 to 10 starts none.
- R10: Any number of wake pulses that arrive during a burst produce exactly one extra burst after it.
- R11: `reinit_i` in ready runs the initialisation and then a burst. The request is cleared as the initialisation starts, so a request raised during the initialisation produces a second initialisation.
- R12: `cmd_valid_o` stays high with stable address and data until `cmd_ready_i`. The sequencer then waits for one response before issuing the next command.
- R13: In states 0 and 3 no command is issued and wakes are ignored. Only `start_i` leaves those states, and it restarts at the soft-reset write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: begin the reset and start sequence |
| reinit_i | input | 1 | Pulse: request re-initialisation |
| wr_valid_i | input | 1 | Pulse: host changed one channel bit |
| wr_idx_i | input | 6 | Channel index of that host write |
| req_state_i | input | 33 | Requested channel state |
| oe_mask_i | input | 33 | Channel enable mask |
| cmd_valid_o | output | 1 | Register write command valid |
| cmd_ready_i | input | 1 | Codec accepts the command |
| cmd_addr_o | output | 5 | Register address |
| cmd_data_o | output | 8 | Register data byte |
| rsp_valid_i | input | 1 | Response for the accepted command |
| rsp_err_i | input | 1 | Reply failed validation |
| drv_state_o | output | 2 | 0 disabled, 1 waiting for init, 2 ready, 3 failed |
| sent_state_o | output | 33 | Effective state of the last complete burst |

## Verification
The bench builds the block with CLK_PER_MS=10, which keeps RESET_MS=3 and REFRESH_MS=7 at their defaults. The settling gap is therefore 30 cycles and the refresh period 70 cycles. Both windows are short enough to be measured directly from recorded command times. Several periodic bursts, early wakes, aborted bursts, double re-initialisation and failure recovery all fit in one short run. The codec response latency is two cycles, so a burst is far shorter than the period. This separates wake-driven bursts from timed ones and lets the bench count the extra burst exactly.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int NUM_CH    = 33;
  localparam int DIRECT_CH = 11;
  localparam int NUM_REGS  = 4;

  localparam logic [4:0] ADDR_RESET = 5'h0C;
  localparam logic [4:0] ADDR_START = 5'h0D;
  localparam logic [4:0] ADDR_CTRL0 = 5'h08;

  typedef enum logic [1:0] {
    ST_DISABLED  = 2'd0,
    ST_WAIT_INIT = 2'd1,
    ST_READY     = 2'd2,
    ST_FAILED    = 2'd3
  } drv_state_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_SEND, PH_RESP, PH_HOLD
  } phase_e;

  // step numbering: 0 soft reset, 1 unlock, 2 power enable, 3..6 control regs
  localparam logic [2:0] STEP_RESET  = 3'd0;
  localparam logic [2:0] STEP_UNLOCK = 3'd1;
  localparam logic [2:0] STEP_POWER  = 3'd2;
  localparam logic [2:0] STEP_CTRL0  = 3'd3;
  localparam logic [2:0] STEP_CTRL3  = 3'd6;

  // channel source of control register r, bit b; -1 means constant zero
  function automatic int ctrl_src(int r, int b);
    int s;
    s = -1;
    case (r)
      0: case (b)
           7: s = 4;  6: s = 5;  5: s = 6;  4: s = 7;
           3: s = 8;  2: s = 23; default: s = -1;
         endcase
      1: case (b)
           7: s = 18; 6: s = 17; 3: s = 0;  2: s = 1;
           1: s = 2;  0: s = 3;  default: s = -1;
         endcase
      2: case (b)
           7: s = 25; 6: s = 24; 5: s = 19; 4: s = 17;
           3: s = 20; 2: s = 21; 1: s = 10; 0: s = 9;
           default: s = -1;
         endcase
      default: case (b)
           5: s = 31; 4: s = 30; 3: s = 29; 2: s = 28;
           1: s = 27; 0: s = 26; default: s = -1;
         endcase
    endcase
    return s;
  endfunction

  // parallel-gated channels carry their enable bit, the rest the request
  function automatic logic [NUM_CH-1:0] effective_state(
      logic [NUM_CH-1:0] req, logic [NUM_CH-1:0] mask);
    logic [NUM_CH-1:0] direct;
    direct = {{(NUM_CH-DIRECT_CH){1'b0}}, {DIRECT_CH{1'b1}}};
    return (req & ~direct) | (mask & direct);
  endfunction

  function automatic logic is_serial_channel(logic [5:0] idx);
    return (int'(idx) >= DIRECT_CH) && (int'(idx) < NUM_CH);
  endfunction

endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int LIMIT = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (expired) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_mapper.sv
module pwr_seq_mapper
  import pwr_seq_pkg::*;
(
  input  logic [NUM_CH-1:0]           state_i,
  output logic [NUM_REGS-1:0][7:0]    fields_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < 8; b++) begin : g_bit
      localparam int SRC = ctrl_src(r, b);
      if (SRC < 0) begin : g_zero
        assign fields_o[r][b] = 1'b0;
      end else begin : g_tap
        assign fields_o[r][b] = state_i[SRC];
      end
    end
  end
endmodule

// File: rtl/pwr_seq_wake.sv
module pwr_seq_wake
  import pwr_seq_pkg::*;
(
  input  logic       wr_valid_i,
  input  logic [5:0] wr_idx_i,
  output logic       wake_o
);
  assign wake_o = wr_valid_i && is_serial_channel(wr_idx_i);
endmodule

// File: rtl/pwr_refresh_seq.sv
module pwr_refresh_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLK_PER_MS = 250000,
  parameter int RESET_MS   = 3,
  parameter int REFRESH_MS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        reinit_i,
  input  logic        wr_valid_i,
  input  logic [5:0]  wr_idx_i,
  input  logic [32:0] req_state_i,
  input  logic [32:0] oe_mask_i,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [4:0]  cmd_addr_o,
  output logic [7:0]  cmd_data_o,
  input  logic        rsp_valid_i,
  input  logic        rsp_err_i,
  output logic [1:0]  drv_state_o,
  output logic [32:0] sent_state_o
);
  localparam int HOLD_CYC = CLK_PER_MS * RESET_MS;
  localparam int PER_CYC  = CLK_PER_MS * REFRESH_MS;

  drv_state_e          state;
  phase_e              ph;
  logic [2:0]          step;
  logic                need_init;
  logic                pending;
  logic [NUM_CH-1:0]   snap;
  logic [NUM_CH-1:0]   sent;
  logic [NUM_CH-1:0]   eff;
  logic [NUM_REGS-1:0][7:0] fields;
  logic [2:0]          rel;

  // named internal events
  logic wake_ev, per_exp, hold_exp;
  logic ev_accept, ev_rsp, ev_ok, ev_err;
  logic burst_done, burst_abort, init_fail;
  logic init_start, burst_start;
  logic idle_ready;

  assign eff = effective_state(req_state_i, oe_mask_i);

  pwr_seq_wake u_wake (
    .wr_valid_i (wr_valid_i),
    .wr_idx_i   (wr_idx_i),
    .wake_o     (wake_ev)
  );

  pwr_seq_mapper u_map (
    .state_i  (snap),
    .fields_o (fields)
  );

  pwr_seq_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ph == PH_HOLD),
    .expired (hold_exp)
  );

  assign idle_ready = (state == ST_READY) && (ph == PH_IDLE);

  pwr_seq_timer #(.LIMIT(PER_CYC)) u_period (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (idle_ready && !need_init),
    .expired (per_exp)
  );

  assign ev_accept   = cmd_valid_o && cmd_ready_i;
  assign ev_rsp      = (ph == PH_RESP) && rsp_valid_i;
  assign ev_ok       = ev_rsp && !rsp_err_i;
  assign ev_err      = ev_rsp && rsp_err_i;
  assign burst_done  = ev_ok  && (step == STEP_CTRL3);
  assign burst_abort = ev_err && (step >= STEP_CTRL0);
  assign init_fail   = ev_err && (step <  STEP_CTRL0);
  assign init_start  = idle_ready && need_init;
  assign burst_start = (idle_ready && !need_init && pending) ||
                       ((state == ST_READY) && ev_ok && (step == STEP_POWER));

  // command encoding
  assign rel         = step - STEP_CTRL0;
  assign cmd_valid_o = (ph == PH_SEND);
  always_comb begin
    cmd_addr_o = ADDR_CTRL0 + {3'b000, rel[1:0]};
    cmd_data_o = fields[rel[1:0]];
    case (step)
      STEP_RESET:  begin cmd_addr_o = ADDR_RESET; cmd_data_o = 8'h02; end
      STEP_UNLOCK: begin cmd_addr_o = ADDR_RESET; cmd_data_o = 8'h00; end
      STEP_POWER:  begin cmd_addr_o = ADDR_START; cmd_data_o = 8'h02; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_DISABLED;
      ph        <= PH_IDLE;
      step      <= STEP_RESET;
      need_init <= 1'b0;
      pending   <= 1'b0;
      snap      <= '0;
      sent      <= '0;
    end else begin
      if (state == ST_READY) begin
        need_init <= (need_init && !init_start) || reinit_i;
        pending   <= (pending && !burst_start) || wake_ev || per_exp;
      end else begin
        need_init <= 1'b0;
        pending   <= 1'b0;
      end

      case (state)
        ST_DISABLED, ST_FAILED: begin
          if (start_i) begin
            state <= ST_WAIT_INIT;
            step  <= STEP_RESET;
            ph    <= PH_SEND;
          end
        end

        ST_WAIT_INIT: begin
          case (ph)
            PH_SEND: if (ev_accept) ph <= PH_RESP;
            PH_RESP: begin
              if (ev_err) begin
                state <= ST_FAILED;
                ph    <= PH_IDLE;
              end else if (ev_ok) begin
                ph <= PH_HOLD;
              end
            end
            PH_HOLD: begin
              if (hold_exp) begin
                state     <= ST_READY;
                ph        <= PH_IDLE;
                need_init <= 1'b1;
              end
            end
            default: ph <= PH_IDLE;
          endcase
        end

        default: begin // ST_READY
          case (ph)
            PH_IDLE: begin
              if (need_init) begin
                step <= STEP_UNLOCK;
                ph   <= PH_SEND;
              end else if (pending) begin
                snap <= eff;
                step <= STEP_CTRL0;
                ph   <= PH_SEND;
              end
            end
            PH_SEND: if (ev_accept) ph <= PH_RESP;
            PH_RESP: begin
              if (ev_err) begin
                ph <= PH_IDLE;
                if (step < STEP_CTRL0) state <= ST_FAILED;
              end else if (ev_ok) begin
                if (step == STEP_CTRL3) begin
                  sent <= snap;
                  ph   <= PH_IDLE;
                end else if (step == STEP_POWER) begin
                  snap <= eff;
                  step <= STEP_CTRL0;
                  ph   <= PH_SEND;
                end else begin
                  step <= step + 3'd1;
                  ph   <= PH_SEND;
                end
              end
            end
            default: ph <= PH_IDLE;
          endcase
        end
      endcase
    end
  end

  assign drv_state_o  = state;
  assign sent_state_o = sent;

endmodule

// File: rtl/pwr_refresh_seq_chk.sv
module pwr_refresh_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [1:0]  drv_state_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [4:0]  cmd_addr_o,
  input logic [7:0]  cmd_data_o,
  input logic [32:0] sent_state_o,
  input logic        burst_done,
  input logic        burst_abort,
  input logic        init_fail
);
  // R13: silent while disabled or failed
  assert_no_cmd_when_down_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_state_o == 2'd0 || drv_state_o == 2'd3) |-> !cmd_valid_o);

  // R13: failed is left only through start
  assert_failed_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_state_o == 2'd3 && !start_i) |=> drv_state_o == 2'd3);

  // R12: command held stable until accepted
  assert_cmd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_data_o)));

  // R4: only the six known register addresses are ever written
  assert_addr_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> (cmd_addr_o >= 5'h08 && cmd_addr_o <= 5'h0D));

  // R2: while waiting for init only the soft-reset write appears
  assert_reset_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && drv_state_o == 2'd1) |-> (cmd_addr_o == 5'h0C && cmd_data_o == 8'h02));

  // R7: an aborted burst leaves the cached state alone
  assert_abort_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_abort |=> $stable(sent_state_o));

  // R7: cached state changes only after a completed burst
  assert_sent_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sent_state_o) |-> $past(burst_done));

  // R3: init error leads to failed
  assert_init_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_fail |=> drv_state_o == 2'd3);
endmodule

bind pwr_refresh_seq pwr_refresh_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .drv_state_o  (drv_state_o),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_addr_o   (cmd_addr_o),
  .cmd_data_o   (cmd_data_o),
  .sent_state_o (sent_state_o),
  .burst_done   (burst_done),
  .burst_abort  (burst_abort),
  .init_fail    (init_fail)
);

// File: tb/pwr_refresh_seq_tb_top.sv
module pwr_refresh_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, reinit_i = 1'b0, wr_valid_i = 1'b0;
  logic [5:0]  wr_idx_i = '0;
  logic [32:0] req_state_i = '0, oe_mask_i = '0;
  logic        cmd_valid_o, cmd_ready_i = 1'b1;
  logic [4:0]  cmd_addr_o;
  logic [7:0]  cmd_data_o;
  logic        rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
  logic [1:0]  drv_state_o;
  logic [32:0] sent_state_o;

  always #2 clk = ~clk;

  pwr_refresh_seq #(.CLK_PER_MS(10), .RESET_MS(3), .REFRESH_MS(7)) dut_i (.*);

  int n_chk = 0, n_fail = 0, cyc = 0, nf = 0, err_idx = -1, cd = 0;
  logic pend_err = 1'b0;
  int   f_addr [0:1023];
  int   f_data [0:1023];
  int   f_time [0:1023];
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // codec model: records accepted commands, answers two cycles later
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid_i = 1'b0;
      if (cd == 1) begin rsp_valid_i = 1'b1; rsp_err_i = pend_err; end
      if (cd > 0) cd--;
      if (cmd_valid_o && cmd_ready_i && nf < 1024) begin
        f_addr[nf] = int'(cmd_addr_o);
        f_data[nf] = int'(cmd_data_o);
        f_time[nf] = cyc;
        pend_err   = (nf == err_idx);
        cd = 2;
        nf++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] tb_eff(logic [32:0] rq, logic [32:0] mk);
    logic [32:0] e;
    for (int i = 0; i < 33; i++) e[i] = (i < 11) ? mk[i] : rq[i];
    return e;
  endfunction

  function automatic logic [7:0] tb_field(int r, logic [32:0] rq, logic [32:0] mk);
    logic [32:0] e;
    e = tb_eff(rq, mk);
    case (r)
      0: return {e[4], e[5], e[6], e[7], e[8], e[23], 2'b00};
      1: return {e[18], e[17], 2'b00, e[0], e[1], e[2], e[3]};
      2: return {e[25], e[24], e[19], e[17], e[20], e[21], e[10], e[9]};
      default: return {2'b00, e[31], e[30], e[29], e[28], e[27], e[26]};
    endcase
  endfunction

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_nf(int n);
    for (int i = 0; i < 400 && nf < n; i++) tick();
  endtask

  task automatic pulse_wake(int idx);
    wr_idx_i = 6'(idx); wr_valid_i = 1'b1; tick(); wr_valid_i = 1'b0;
  endtask

  task automatic pulse_reinit();
    reinit_i = 1'b1; tick(); reinit_i = 1'b0;
  endtask

  task automatic pulse_start();
    start_i = 1'b1; tick(); start_i = 1'b0;
  endtask

  task automatic chk_frame(int i, int a, int d, string req);
    chk(f_addr[i] == a, req, f_addr[i], a);
    chk(f_data[i] == d, req, f_data[i], d);
  endtask

  task automatic chk_burst(int b, string req);
    for (int k = 0; k < 4; k++)
      chk_frame(b + k, 8 + k, int'(tb_field(k, req_state_i, oe_mask_i)), req);
  endtask

  task automatic chk_init(int b, string req);
    chk_frame(b, 'h0C, 'h00, req);
    chk_frame(b + 1, 'h0D, 'h02, req);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    int base, t0;
    logic [32:0] old_sent;
    void'($urandom(32'd1234));
    tick(3); rst_n = 1'b1; tick(2);
    // R1 reset state
    chk(drv_state_o == 2'd0, "R1", drv_state_o, 0);
    chk(!cmd_valid_o, "R1", cmd_valid_o, 0);
    chk(sent_state_o == '0, "R1", int'(sent_state_o[31:0]), 0);
    pulse_wake(20); tick(20);
    chk(nf == 0, "R1", nf, 0);

    // start, reset, init, first burst
    req_state_i = 33'h1_5A5A_A5A5; oe_mask_i = 33'h0_0000_0555;
    pulse_start();
    wait_nf(1);
    chk_frame(0, 'h0C, 'h02, "R2");
    chk(drv_state_o == 2'd1, "R2", drv_state_o, 1);
    wait_nf(7); tick(4);
    chk((f_time[1] - f_time[0]) >= 32 && (f_time[1] - f_time[0]) <= 40, "R2",
        f_time[1] - f_time[0], 34);
    chk_init(1, "R3");
    chk_burst(3, "R4 R5 R6");
    chk(drv_state_o == 2'd2, "R4", drv_state_o, 2);
    chk(sent_state_o == tb_eff(req_state_i, oe_mask_i), "R7",
        int'(sent_state_o[31:0]), int'(tb_eff(req_state_i, oe_mask_i)));

    // R8 period
    wait_nf(11);
    t0 = f_time[7] - f_time[6];
    chk(t0 >= 72 && t0 <= 80, "R8", t0, 74);
    chk_burst(7, "R8");
    tick(6);

    // R9 early wake on serial channel
    t0 = cyc; base = nf;
    pulse_wake(20);
    wait_nf(base + 4);
    chk(f_time[base] - t0 <= 6, "R9", f_time[base] - t0, 3);
    tick(5);
    // R9 direct channel does not wake
    base = nf;
    pulse_wake(3); tick(30);
    chk(nf == base, "R9", nf, base);
    wait_nf(base + 4); tick(5);

    // random patterns
    for (int it = 0; it < 8; it++) begin
      req_state_i = {1'($urandom), $urandom};
      oe_mask_i   = {1'($urandom), $urandom};
      base = nf;
      pulse_wake(11 + int'($urandom % 22));
      wait_nf(base + 4); tick(4);
      chk_burst(base, "R5 R6");
      chk(sent_state_o == tb_eff(req_state_i, oe_mask_i), "R7",
          int'(sent_state_o[31:0]), int'(tb_eff(req_state_i, oe_mask_i)));
    end

    // R7 abort on second frame
    old_sent = sent_state_o;
    req_state_i = ~req_state_i; oe_mask_i = ~oe_mask_i;
    base = nf; err_idx = base + 1;
    pulse_wake(32);
    wait_nf(base + 2); tick(20);
    chk(nf == base + 2, "R7", nf, base + 2);
    chk(sent_state_o == old_sent, "R7", int'(sent_state_o[31:0]), int'(old_sent[31:0]));
    err_idx = -1;

    // R10 wakes during a burst give one extra burst
    base = nf;
    pulse_wake(15);
    wait_nf(base + 1);
    pulse_wake(16); tick(2); pulse_wake(17);
    wait_nf(base + 8); tick(20);
    chk(nf == base + 8, "R10", nf, base + 8);

    // R12 handshake hold
    cmd_ready_i = 1'b0;
    base = nf;
    pulse_wake(12); tick(3);
    chk(cmd_valid_o && cmd_addr_o == 5'h08, "R12", cmd_addr_o, 8);
    tick(8);
    chk(cmd_valid_o && cmd_addr_o == 5'h08 && nf == base, "R12", cmd_addr_o, 8);
    cmd_ready_i = 1'b1;
    wait_nf(base + 4); tick(5);

    // R11 reinit
    base = nf;
    pulse_reinit();
    wait_nf(base + 6); tick(4);
    chk_init(base, "R11");
    chk_burst(base + 2, "R11");
    // R11 reinit raised during init
    base = nf;
    pulse_reinit();
    wait_nf(base + 1);
    pulse_reinit();
    wait_nf(base + 12); tick(4);
    chk_init(base, "R11");
    chk_init(base + 6, "R11");
    chk_burst(base + 8, "R11");

    // R3 init failure
    base = nf; err_idx = base + 1;
    pulse_reinit();
    wait_nf(base + 2); tick(6);
    chk(drv_state_o == 2'd3, "R3", drv_state_o, 3);
    pulse_wake(25); tick(100);
    chk(nf == base + 2, "R13", nf, base + 2);
    err_idx = -1;

    // R13 restart, R2 reset frame error
    base = nf; err_idx = base;
    pulse_start();
    wait_nf(base + 1); tick(6);
    chk_frame(base, 'h0C, 'h02, "R13");
    chk(drv_state_o == 2'd3, "R2", drv_state_o, 3);
    err_idx = -1;
    base = nf;
    pulse_start();
    wait_nf(base + 7); tick(5);
    chk_init(base + 1, "R13");
    chk(drv_state_o == 2'd2, "R13", drv_state_o, 2);

    finished = 1;
    finish_run();
  end
endmodule